// File: doc/BRIEF.md
# Square-Wave Interval Timer Channel

This block is a single 16-bit down-counting channel of an interval timer. It runs in one mode only: square-wave generation with automatic reload. A host programs it over an 8-bit write port. It first writes a control word that selects this channel and the square-wave configuration. It then writes the initial count as two bytes, least significant byte first. Once the second byte arrives, the channel drives a periodic waveform on its output pin. The period of that waveform is the programmed count, measured in counting clocks.

Counting advances on each rising edge of `clk` where `cnt_tick` is high. The gate input controls the channel. While the gate is low, the output is forced high and counting stops. When the gate rises, the count reloads and a fresh period begins. The host may write a new count while the channel runs. The running half-period finishes unchanged, and the new value is used from the next half-period reload onward.

For an odd count the waveform is not symmetric. The high half lasts one clock longer than the low half.

Top module: `pit_sqwave_chan`

## Requirements
- R1: After reset, and at any time before a count has been committed following an accepted control word, `out_wave` is high and does not toggle.
- R2: A control word is a write with `wr_ctrl`=1. Its fields are:
  - bits [7:6]: channel select.
  - bits [5:4]: access order.
  - bits [3:1]: mode.
  - bit 0: number format.

  A control word is accepted only when all of these hold: select equals `CHAN_ID` (0 by default), access order is 2'b11, mode bits [2:1] are 2'b11, and bit 0 is 0. For example, 0x36 is accepted, while 0x76 and 0x34 are not. A word that is not accepted has no effect on the output or on the byte order.
- R3: Count bytes are writes with `wr_ctrl`=0.
  - The first byte after an accepted control word is the low byte, and the next byte is the high byte.
  - Writing the high byte commits the 16-bit count.
  - Count bytes written before any accepted control word are ignored.
- R4: After a committed count with no waveform running, the channel spends one counting clock loading. The first high phase therefore lasts ceil(N/2)+1 clocks, measured from the clock after the high-byte write.
- R5: For an even count N, the output alternates high for N/2 clocks and low for N/2 clocks. A count of 10 gives a period of 10 clocks.
- R6: For an odd count N, the output is high for (N+1)/2 clocks and low for (N-1)/2 clocks.
- R7: A count of 0 acts as 65536, giving 32768 clocks high and 32768 clocks low. The largest count, 0xFFFF, gives 32768 clocks high and 32767 clocks low.
- R8: A count of 1 acts as 2, giving one clock high and one clock low.
- R9: On a clock with `cnt_tick` low, neither the output nor the phase position changes.
- R10: While `gate` is low, the output is high (from the next clock) and counting stops. A rising gate reloads the count, so the first high phase lasts ceil(N/2)+1 clocks after the rise.
- R11: A count committed while the waveform runs does not shorten or lengthen the half-period in progress. It takes effect at the next reload. If the commit falls on the same clock as a reload, that reload still uses the previous count.
- R12: An accepted control word written while the waveform runs stops it. The output stays high until a new count is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one clock per byte |
| wr_ctrl | input | 1 | 1: byte is a control word; 0: byte is a count byte |
| wr_data | input | 8 | Host write byte |
| cnt_tick | input | 1 | Counting clock enable; one count per clock where high |
| gate | input | 1 | Counting gate; low forces output high and stops, rising edge reloads |
| out_wave | output | 1 | Square-wave output |

## Verification
Two events can fall on the same clock: the commit of a count's high byte and the half-period reload that reads the count. The bench first observes a rising output edge. From the known half-period length, it then places the high-byte write on exactly the clock where the output falls. The bench checks that the low half that follows still has the old count's length, and that only the next high and low halves take the new count's lengths. A second case writes the new count in the middle of a high phase and checks that only the remainder of that phase is unchanged.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [CNT_W:0]   span_t;

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] access;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    localparam logic [1:0] ACC_LO_THEN_HI = 2'b11;
    localparam logic [1:0] MODE_SQUARE    = 2'b11;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_RUN
    } phase_st_t;

    localparam count_t HALF_MAX = count_t'(1) << (CNT_W - 1);

    function automatic logic ctrl_is_square(ctrl_word_t c);
        return (c.access == ACC_LO_THEN_HI) && (c.mode[1:0] == MODE_SQUARE) && !c.bcd;
    endfunction

    function automatic span_t eff_span(count_t n);
        if (n == '0)
            return span_t'(1) << CNT_W;
        else if (n == count_t'(1))
            return span_t'(2);
        else
            return span_t'(n);
    endfunction

    function automatic count_t high_len(count_t n);
        span_t s;
        span_t h;
        s = eff_span(n);
        h = (s + span_t'(1)) >> 1;
        return h[CNT_W-1:0];
    endfunction

    function automatic count_t low_len(count_t n);
        span_t s;
        span_t l;
        s = eff_span(n);
        l = s >> 1;
        return l[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/pit_host_port.sv
module pit_host_port
    import pit_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              arm,
    output logic              commit,
    output count_t            count_q
);

    ctrl_word_t        cw;
    logic              cfg_q;
    logic              hi_next_q;
    logic [BYTE_W-1:0] lo_q;
    logic              cw_accept;

    assign cw        = ctrl_word_t'(wr_data);
    assign cw_accept = (cw.sel == 2'(CHAN_ID)) && ctrl_is_square(cw);
    assign arm       = wr_en && wr_ctrl && cw_accept;
    assign commit    = wr_en && !wr_ctrl && cfg_q && hi_next_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= 1'b0;
            hi_next_q <= 1'b0;
            lo_q      <= '0;
            count_q   <= '0;
        end else if (arm) begin
            cfg_q     <= 1'b1;
            hi_next_q <= 1'b0;
        end else if (wr_en && !wr_ctrl && cfg_q) begin
            if (hi_next_q) begin
                count_q   <= {wr_data, lo_q};
                hi_next_q <= 1'b0;
            end else begin
                lo_q      <= wr_data;
                hi_next_q <= 1'b1;
            end
        end
    end

    AST_ARM_RESTARTS_ORDER: assert property (@(posedge clk) disable iff (rst)
        arm |=> !hi_next_q); // R3

    AST_FOREIGN_CTRL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl && !cw_accept) |=> ($stable(hi_next_q) && $stable(cfg_q) && $stable(count_q))); // R2

    AST_ORPHAN_BYTE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ctrl && !cfg_q) |=> ($stable(hi_next_q) && $stable(count_q))); // R3

endmodule

// File: rtl/pit_phase_gen.sv
module pit_phase_gen
    import pit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   gate,
    input  logic   arm,
    input  logic   commit,
    input  count_t count_q,
    output logic   out_q
);

    phase_st_t st_q;
    count_t    rem_q;
    logic      gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PH_IDLE;
            rem_q  <= '0;
            out_q  <= 1'b1;
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate;
            if (arm) begin
                st_q  <= PH_IDLE;
                out_q <= 1'b1;
            end else begin
                unique case (st_q)
                    PH_IDLE: begin
                        out_q <= 1'b1;
                        if (commit)
                            st_q <= PH_LOAD;
                    end
                    PH_LOAD: begin
                        out_q <= 1'b1;
                        if (gate && gate_q && tick) begin
                            rem_q <= high_len(count_q);
                            st_q  <= PH_RUN;
                        end
                    end
                    PH_RUN: begin
                        if (!gate) begin
                            out_q <= 1'b1;
                        end else if (!gate_q) begin
                            st_q <= PH_LOAD;
                        end else if (tick) begin
                            if (rem_q <= count_t'(1)) begin
                                if (out_q) begin
                                    out_q <= 1'b0;
                                    rem_q <= low_len(count_q);
                                end else begin
                                    out_q <= 1'b1;
                                    rem_q <= high_len(count_q);
                                end
                            end else begin
                                rem_q <= rem_q - count_t'(1);
                            end
                        end
                    end
                    default: st_q <= PH_IDLE;
                endcase
            end
        end
    end

    AST_STOPPED_OUT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st_q != PH_RUN) |-> out_q); // R1

    AST_GATE_LOW_FORCES_HIGH: assert property (@(posedge clk) disable iff (rst)
        !gate |=> out_q); // R10

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_RUN && gate && gate_q && !tick && !arm) |=> ($stable(out_q) && $stable(rem_q))); // R9

    AST_PHASE_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_RUN) |-> (rem_q != '0 && rem_q <= HALF_MAX)); // R7

endmodule

// File: rtl/pit_sqwave_chan.sv
module pit_sqwave_chan
    import pit_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_ctrl,
    input  logic [7:0] wr_data,
    input  logic       cnt_tick,
    input  logic       gate,
    output logic       out_wave
);

    logic   arm;
    logic   commit;
    count_t count_q;

    pit_host_port #(
        .CHAN_ID(CHAN_ID)
    ) u_host (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ctrl (wr_ctrl),
        .wr_data (wr_data),
        .arm     (arm),
        .commit  (commit),
        .count_q (count_q)
    );

    pit_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick    (cnt_tick),
        .gate    (gate),
        .arm     (arm),
        .commit  (commit),
        .count_q (count_q),
        .out_q   (out_wave)
    );

endmodule

// File: tb/test_pit_sqwave_chan.sv
module test_pit_sqwave_chan;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic       wr_ctrl;
    logic [7:0] wr_data;
    logic       cnt_tick;
    logic       gate;
    logic       out_wave;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pit_sqwave_chan i_pit_sqwave_chan (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_ctrl  (wr_ctrl),
        .wr_data  (wr_data),
        .cnt_tick (cnt_tick),
        .gate     (gate),
        .out_wave (out_wave)
    );

    function automatic int eff_n(int n);
        if (n == 0) return 65536;
        if (n == 1) return 2;
        return n;
    endfunction

    function automatic int exp_hi(int n);
        return (eff_n(n) + 1) / 2;
    endfunction

    function automatic int exp_lo(int n);
        return eff_n(n) / 2;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic is_ctrl, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_ctrl = is_ctrl;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic load_count(input int n);
        logic [15:0] v;
        v = 16'(n);
        wr(1'b0, v[7:0]);
        wr(1'b0, v[15:8]);
    endtask

    task automatic start(input int n);
        wr(1'b1, 8'h36);
        load_count(n);
    endtask

    task automatic run_len(input logic lvl, output int len);
        len = 0;
        while (out_wave === lvl) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic hold(input logic lvl, input int cycles, input string req);
        int bad;
        bad = 0;
        repeat (cycles) begin
            if (out_wave !== lvl) bad++;
            @(negedge clk);
        end
        check(req, bad, 0);
    endtask

    task automatic period_check(input string req, input int n);
        int l;
        run_len(1'b1, l); check(req, l, exp_hi(n) + 1);
        run_len(1'b0, l); check(req, l, exp_lo(n));
        run_len(1'b1, l); check(req, l, exp_hi(n));
        run_len(1'b0, l); check(req, l, exp_lo(n));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int l;
        int n;
        rst      = 1'b1;
        wr_en    = 1'b0;
        wr_ctrl  = 1'b0;
        wr_data  = '0;
        cnt_tick = 1'b1;
        gate     = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check("R1 reset level", int'(out_wave), 1);

        // R3: count bytes before any control word are ignored
        load_count(10);
        hold(1'b1, 30, "R3 orphan count");

        // R4 / R5: count 10
        start(10);
        period_check("R5 even 10", 10);

        // R12: control word mid-run stops output high
        wr(1'b1, 8'h36);
        check("R12 stop level", int'(out_wave), 1);
        hold(1'b1, 20, "R12 held");
        load_count(7);
        period_check("R6 odd 7", 7);

        // R8: count 1 acts as 2
        start(1);
        period_check("R8 count one", 1);

        // R2: foreign and non-square control words are ignored
        start(10);
        run_len(1'b1, l); check("R4 first high", l, 6);
        wr(1'b1, 8'h76);
        wr(1'b1, 8'h34);
        run_len(1'b0, l); check("R2 low rest", l, 3);
        run_len(1'b1, l); check("R2 high", l, 5);
        run_len(1'b0, l); check("R2 low", l, 5);

        // R11: high byte committed on the reload clock
        wr(1'b0, 8'd7);
        repeat (3) @(negedge clk);
        wr(1'b0, 8'd0);
        check("R11 fall on commit", int'(out_wave), 0);
        run_len(1'b0, l); check("R11 old low", l, 5);
        run_len(1'b1, l); check("R11 new high", l, 4);
        run_len(1'b0, l); check("R11 new low", l, 3);

        // R11: commit mid high phase
        load_count(12);
        run_len(1'b1, l); check("R11 rest of high", l, 2);
        run_len(1'b0, l); check("R11 low 12", l, 6);
        run_len(1'b1, l); check("R11 high 12", l, 6);
        run_len(1'b0, l); check("R11 low 12 again", l, 6);

        // R9: tick low freezes the phase
        cnt_tick = 1'b0;
        hold(1'b1, 20, "R9 frozen");
        cnt_tick = 1'b1;
        run_len(1'b1, l); check("R9 high resumes", l, 6);

        // R10: gate low forces high, rise reloads
        gate = 1'b0;
        @(negedge clk);
        hold(1'b1, 15, "R10 gate low");
        gate = 1'b1;
        @(negedge clk);
        run_len(1'b1, l); check("R10 first high", l, 7);
        run_len(1'b0, l); check("R10 low", l, 6);

        // Random counts with a fixed seed
        void'($urandom(32'd2024));
        for (int i = 0; i < 6; i++) begin
            n = 2 + int'($urandom % 299);
            start(n);
            period_check((n % 2) ? "R6 random odd" : "R5 random even", n);
        end

        // R7: largest and zero counts
        start(16'hFFFF);
        run_len(1'b1, l); check("R7 max high", l, 32769);
        run_len(1'b0, l); check("R7 max low", l, 32767);
        start(0);
        run_len(1'b1, l); check("R7 zero high", l, 32769);
        run_len(1'b0, l); check("R7 zero low", l, 32768);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule